// File: doc/BRIEF.md
# OOK Half-Duplex Direction Controller

This block decides, cycle by cycle, which way a half-duplex on-off-keyed line modem is talking. A carrier-detect flag from the analog receiver arrives asynchronously. It is brought into the clock domain through a flop chain and then drives a direction flag. When the direction flag is low, the host may transmit. When it is high, a frame is arriving, and the block shows the carrier state on an active-low receive data line.

After the last carrier edge, the receive direction is held for a dwell of a fixed number of bit periods. A single-cycle bit tick from the baud generator marks each bit period. Every carrier edge restarts this dwell, so the line returns to transmit-ready only after it has been quiet long enough. A transmit request comes either from an active-low data pin or from a register bit. The request produces a transmit-active flag that gates the power amplifier. That flag is forced off while a receive is in progress.

The three outputs are also presented as a packed status word. A host that sees only registers can therefore run the modem without touching the pins.

Top module: `ook_dir_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, dir_o is 0, rx_data_o is 1, tx_active_o follows R6, and status_o is consistent with R8.
- R2: carrier_i is sampled through a chain of SYNC_STAGES flops (default 2). The cycle after the synchronized carrier is seen high while dir_o is 0, dir_o becomes 1.
- R3: dir_o falls back to 0 only when DWELL_BITS bit ticks (default 16) have been counted since the last carrier edge and the synchronized carrier is low. dir_o never falls while the synchronized carrier is high.
- R4: Every edge of the synchronized carrier, rising or falling, restarts the dwell count at zero. A bit tick in the same cycle as an edge is not counted.
- R5: rx_data_o is 0 when dir_o is 1 and the synchronized carrier is high. In every other case it is 1, including every cycle with dir_o at 0.
- R6: While dir_o is 0, tx_active_o equals tx_reg_i OR (NOT tx_data_n_i), combinationally.
- R7: While dir_o is 1, tx_active_o is 0 whatever the transmit pin or register bit hold.
- R8: status_o bit 0 mirrors dir_o, bit 1 mirrors rx_data_o, and bit 2 mirrors tx_active_o, with the same polarity as the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_i | input | 1 | Asynchronous carrier-detect flag, high when carrier present |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| tx_data_n_i | input | 1 | Transmit data pin, low requests carrier |
| tx_reg_i | input | 1 | Register transmit bit, high requests carrier |
| dir_o | output | 1 | Direction: 0 transmit-ready, 1 receive in progress |
| rx_data_o | output | 1 | Receive data, low while carrier on during receive |
| tx_active_o | output | 1 | Power amplifier gate |
| status_o | output | 3 | Mirror: {tx_active, rx_data, dir} |

## Verification
The clash that matters is a carrier edge landing in the same cycle as the bit tick that would otherwise expire the dwell. The edge must win: the count restarts and the direction stays high. This is provoked by a phase that raises the tick every cycle and moves the carrier at spacings close to the dwell length. A second phase pulses the carrier just before expiry at a slower tick rate. A behavioural model with integer counters predicts direction, receive data and transmit-active on every clock, and a late restart or a lost one shows up as a mismatch in the cycle where the direction falls.

// File: rtl/ook_dir_pkg.sv
package ook_dir_pkg;

  // Bit positions matter: a host decodes this word.
  typedef struct packed {
    logic tx_active;  // bit 2
    logic rx_data;    // bit 1
    logic dir;        // bit 0
  } ook_stat_t;

  localparam int unsigned DEF_DWELL_BITS  = 16;
  localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/ook_sync_chain.sv
module ook_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ook_dwell_timer.sv
module ook_dwell_timer #(
  parameter int unsigned DWELL_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_s_i,
  input  logic bit_tick_i,
  output logic dir_o
);

  localparam int unsigned CW = $clog2(DWELL_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(DWELL_BITS - 1);
  localparam logic [CW-1:0] FULL = CW'(DWELL_BITS);

  logic          prev_q, dir_q, dir_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          edge_s, cnt_en, expire;

  assign edge_s = carrier_s_i ^ prev_q;
  assign cnt_en = dir_q & bit_tick_i & ~edge_s & (cnt_q != FULL);
  assign expire = cnt_en & (cnt_q == LAST) & ~carrier_s_i;

  always_comb begin
    dir_d = dir_q;
    cnt_d = cnt_q;
    if (!dir_q) begin
      cnt_d = '0;
      if (carrier_s_i) dir_d = 1'b1;
    end else if (edge_s) begin
      cnt_d = '0;
    end else if (expire) begin
      dir_d = 1'b0;
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      dir_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= carrier_s_i;
      dir_q  <= dir_d;
      cnt_q  <= cnt_d;
    end
  end

  assign dir_o = dir_q;

  AST_ENTER_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_q && carrier_s_i) |=> dir_q);  // R2
  AST_HOLD_ON_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q && carrier_s_i) |=> dir_q);  // R3
  AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q && edge_s) |=> (cnt_q == '0));  // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);  // R4

endmodule

// File: rtl/ook_tx_gate.sv
module ook_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_data_n_i,
  input  logic tx_reg_i,
  input  logic dir_i,
  output logic tx_active_o
);

  logic tx_req;

  assign tx_req      = tx_reg_i | ~tx_data_n_i;
  assign tx_active_o = tx_req & ~dir_i;

  AST_TX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    dir_i |-> !tx_active_o);  // R7
  AST_TX_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active_o |-> (tx_reg_i || !tx_data_n_i));  // R6

endmodule

// File: rtl/ook_dir_ctrl.sv
module ook_dir_ctrl
  import ook_dir_pkg::*;
#(
  parameter int unsigned DWELL_BITS  = DEF_DWELL_BITS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       carrier_i,
  input  logic       bit_tick_i,
  input  logic       tx_data_n_i,
  input  logic       tx_reg_i,
  output logic       dir_o,
  output logic       rx_data_o,
  output logic       tx_active_o,
  output logic [2:0] status_o
);

  logic      carrier_s;
  logic      dir_w, tx_act_w, rxd_w;
  ook_stat_t stat;

  ook_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (carrier_i),
    .q_o   (carrier_s)
  );

  ook_dwell_timer #(.DWELL_BITS(DWELL_BITS)) u_dwell (
    .clk         (clk),
    .rst_n       (rst_n),
    .carrier_s_i (carrier_s),
    .bit_tick_i  (bit_tick_i),
    .dir_o       (dir_w)
  );

  ook_tx_gate u_txg (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_data_n_i (tx_data_n_i),
    .tx_reg_i    (tx_reg_i),
    .dir_i       (dir_w),
    .tx_active_o (tx_act_w)
  );

  assign rxd_w = ~(dir_w & carrier_s);

  always_comb begin
    stat.dir       = dir_w;
    stat.rx_data   = rxd_w;
    stat.tx_active = tx_act_w;
  end

  assign dir_o       = dir_w;
  assign rx_data_o   = rxd_w;
  assign tx_active_o = tx_act_w;
  assign status_o    = stat;

  AST_RX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_o |-> rx_data_o);  // R5
  AST_NO_TX_AND_RX: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_active_o && !rx_data_o));  // R7

endmodule

// File: tb/sim_ook_dir_ctrl.sv
module sim_ook_dir_ctrl;

  localparam int DWELL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic carrier = 1'b0, tick = 1'b0, txn = 1'b1, treg = 1'b0;
  logic dir, rxd, txa;
  logic [2:0] st;

  int total = 0, bad = 0, cyc = 0;
  int tick_per = 4, tick_cnt = 0, tick_pct = 0;
  bit finished = 0;

  // behavioural model state
  int m_s1 = 0, m_s2 = 0, m_prev = 0, m_dir = 0, m_cnt = 0;

  always #2.5 clk = ~clk;

  ook_dir_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .carrier_i(carrier), .bit_tick_i(tick),
    .tx_data_n_i(txn), .tx_reg_i(treg), .dir_o(dir), .rx_data_o(rxd),
    .tx_active_o(txa), .status_o(st)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_dir = 0; m_cnt = 0;
    end else begin
      if (m_dir == 0) begin
        m_cnt = 0;
        if (m_s2 == 1) m_dir = 1;
      end else if (m_s2 != m_prev) begin
        m_cnt = 0;
      end else if (tick && m_cnt < DWELL) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == DWELL && m_s2 == 0) begin m_dir = 0; m_cnt = 0; end
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = carrier;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // compare every cycle, before inputs move
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      int e_rx, e_tx;
      e_rx = (m_dir == 1 && m_s2 == 1) ? 0 : 1;
      e_tx = m_dir ? 0 : ((treg || !txn) ? 1 : 0);
      chk("R2 R3 R4 dir", dir, m_dir);
      chk("R5 rx_data", rxd, e_rx);
      if (m_dir) chk("R7 tx_active blocked", txa, 0);
      else       chk("R6 tx_active", txa, e_tx);
      chk("R8 status", st, {txa, rxd, dir});
    end
    // tick generator
    if (tick_pct > 0) tick <= (($urandom % 100) < tick_pct);
    else begin
      tick <= (tick_cnt == 0);
      tick_cnt = (tick_cnt + 1 >= tick_per) ? 0 : tick_cnt + 1;
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    wait_n(150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

  initial begin
    // R1: reset state
    wait_n(2);
    chk("R1 dir in reset", dir, 0);
    chk("R1 rx_data in reset", rxd, 1);
    chk("R1 status in reset", st, 3'b010);
    rst_n = 1'b1;
    wait_n(1);
    chk("R1 dir after reset", dir, 0);
    chk("R1 rx_data after reset", rxd, 1);
    // R6: both request sources while idle
    txn = 0; wait_n(10); txn = 1; treg = 1; wait_n(10);
    txn = 0; wait_n(5); treg = 0; txn = 1; wait_n(5);
    // R2 R3 R7: a burst with transmit attempts during receive
    carrier = 1; txn = 0; wait_n(30); carrier = 0; treg = 1;
    wait_n(DWELL * 4 + 20); txn = 1; treg = 0;
    // R3: long steady carrier with fast ticks, count saturates
    tick_per = 1; carrier = 1; wait_n(200); carrier = 0; wait_n(40);
    // R4: pulses just inside and outside the dwell
    tick_per = 4;
    for (int k = 0; k < 6; k++) begin
      carrier = 1; wait_n(3); carrier = 0; wait_n(DWELL * 4 - 6 + k * 2);
    end
    wait_n(80);
    // R4: tick each cycle, edges near expiry so edge and tick coincide
    tick_per = 1;
    for (int k = 0; k < 8; k++) begin
      carrier = 1; wait_n(2); carrier = 0; wait_n(DWELL - 3 + k);
    end
    wait_n(40);
    // mixed random traffic
    tick_pct = 30;
    for (int k = 0; k < 8000; k++) begin
      if (($urandom % 100) < 4) carrier = ~carrier;
      if (($urandom % 100) < 5) txn = ~txn;
      if (($urandom % 100) < 5) treg = ~treg;
      wait_n(1);
    end
    carrier = 0; txn = 1; treg = 0; wait_n(200);
    chk("R3 idle at end", dir, 0);
    wrap_up();
  end

endmodule